// File: doc/BRIEF.md
# Flag-synchronised character I/O port

This block is the character input/output unit beside a 16-bit accumulator datapath. It holds one received character with a "character waiting" flag, one character to transmit with a "transmitter idle" flag, and an interrupt-enable bit. A keyboard-side source deposits characters and a printer-side sink takes them. The two flags carry the whole handshake between the processor and the device. The processor clears a flag when it takes or supplies a character. The device sets it again when it supplies or takes one.

The processor drives the unit during the third timing step of an I/O instruction. That is the cycle where the decoded opcode is 111, the indirect bit is 1 and T3 is high. Six selector bits, taken from instruction bits 11 down to 6, choose the operations. The unit answers in the same cycle with three requests: a sequence-counter clear, a PC skip, and an accumulator write carrying the merged accumulator value. Its own state is updated at the clock edge that ends that cycle. An interrupt request is raised whenever interrupts are enabled and either flag is set.

Top module: `char_io_port`

## Requirements
- R1: After synchronous reset the port shows kb_ready=1 (input flag 0), pr_valid=0 (output flag 1), pr_data=0, irq=0, and both character registers hold 0.
- R2: The unit is active only when dec_d7, ir_ind and t3 are all 1. While it is active sc_clear=1. While it is inactive, sc_clear, pc_skip and acc_we are 0 and no selector bit changes any state.
- R3: Selector bit 5 (instruction bit 11, word F800h) sets acc_we=1 with acc_out = {acc_in[15:8], received character}. It clears the input flag at the edge.
- R4: Selector bit 4 (instruction bit 10, word F400h) loads acc_in[7:0] into the output register and clears the output flag at the edge.
- R5: Selector bit 3 (instruction bit 9, word F200h) raises pc_skip when the input flag is 1.
- R6: Selector bit 2 (instruction bit 8, word F100h) raises pc_skip when the output flag is 1.
- R7: Selector bit 1 (instruction bit 7, word F080h) sets interrupt enable. Selector bit 0 (instruction bit 6, word F040h) clears it. When both are set, clearing wins.
- R8: kb_ready is the inverse of the input flag. When kb_valid=1 and kb_ready=1, kb_data is stored and the flag is set. kb_valid while kb_ready=0 is ignored.
- R9: pr_valid is the inverse of the output flag and pr_data shows the output register. pr_ack while pr_valid=1 sets the flag. pr_ack while pr_valid=0 has no effect.
- R10: irq = interrupt enable AND (input flag OR output flag).
- R11: If a device load and an input instruction fall in the same cycle, the load wins. The flag ends at 1 and the new character is kept, while acc_out in that cycle carries the previous character.
- R12: If an output instruction and pr_ack fall in the same cycle, the instruction wins. pr_valid stays 1 and shows the new character.
- R13: Several selector bits in one word act together. With both skip bits set, pc_skip is the OR of the two tests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_d7 | input | 1 | Opcode decoder output for opcode 111 |
| ir_ind | input | 1 | Instruction bit 15 (indirect/I/O select) |
| t3 | input | 1 | Timing step T3 |
| ir_sel | input | 6 | Instruction bits 11..6 |
| acc_in | input | 16 | Current accumulator value |
| acc_out | output | 16 | Accumulator value with the received character merged in |
| acc_we | output | 1 | Request to write acc_out into the accumulator |
| pc_skip | output | 1 | Request to increment the PC |
| sc_clear | output | 1 | Request to clear the sequence counter |
| kb_valid | input | 1 | Device offers a character |
| kb_data | input | 8 | Offered character |
| kb_ready | output | 1 | Input register free (input flag 0) |
| pr_valid | output | 1 | Output character pending (output flag 0) |
| pr_data | output | 8 | Pending output character |
| pr_ack | input | 1 | Device takes the pending character |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the same-cycle collisions between the processor and the device. One is a character arriving exactly when an input instruction executes. The other is an acknowledge landing on the same edge as a new output instruction. Each needs the matching flag driven into a known state first. The bench therefore replays a table that walks both flags and the enable bit through their states, then drives instruction and device stimulus together in one cycle. A follow-up skip or input instruction shows which side won.

// File: rtl/cio_pkg.sv
package cio_pkg;

    localparam int DEF_ACC_W  = 16;
    localparam int DEF_CHAR_W = 8;
    // selector bits are instruction bits 11..6
    localparam int N_CMD      = 6;

    // field order matches ir_sel[5:0] (instruction bits 11..6)
    typedef struct packed {
        logic take_char;   // bit 11
        logic put_char;    // bit 10
        logic skip_in;     // bit 9
        logic skip_out;    // bit 8
        logic int_on;      // bit 7
        logic int_off;     // bit 6
    } io_cmd_t;

    function automatic logic skip_request(input io_cmd_t c,
                                          input logic in_flag,
                                          input logic out_flag);
        return (c.skip_in & in_flag) | (c.skip_out & out_flag);
    endfunction

    function automatic logic irq_request(input logic enable,
                                         input logic in_flag,
                                         input logic out_flag);
        return enable & (in_flag | out_flag);
    endfunction

endpackage

// File: rtl/cio_decode.sv
module cio_decode
    import cio_pkg::*;
(
    input  logic             dec_d7,
    input  logic             ir_ind,
    input  logic             t3,
    input  logic [N_CMD-1:0] ir_sel,
    output logic             active,
    output io_cmd_t          cmd
);
    logic [N_CMD-1:0] gated;

    assign active = dec_d7 & ir_ind & t3;

    for (genvar g = 0; g < N_CMD; g++) begin : g_gate
        assign gated[g] = active & ir_sel[g];
    end

    assign cmd = io_cmd_t'(gated);
endmodule

// File: rtl/cio_in_chan.sv
module cio_in_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dev_valid,
    input  logic [W-1:0] dev_data,
    input  logic         cpu_take,
    output logic         dev_ready,
    output logic [W-1:0] char_q,
    output logic         flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            char_q <= '0;
            flag_q <= 1'b0;
        end else if (dev_valid && !flag_q) begin
            // device load wins over a same-cycle take
            char_q <= dev_data;
            flag_q <= 1'b1;
        end else if (cpu_take) begin
            flag_q <= 1'b0;
        end
    end

    assign dev_ready = ~flag_q;
endmodule

// File: rtl/cio_out_chan.sv
module cio_out_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cpu_load,
    input  logic [W-1:0] cpu_data,
    input  logic         dev_ack,
    output logic         dev_valid,
    output logic [W-1:0] char_q,
    output logic         flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            char_q <= '0;
            flag_q <= 1'b1;
        end else if (cpu_load) begin
            // new character wins over a same-cycle acknowledge
            char_q <= cpu_data;
            flag_q <= 1'b0;
        end else if (dev_ack && !flag_q) begin
            flag_q <= 1'b1;
        end
    end

    assign dev_valid = ~flag_q;
endmodule

// File: rtl/cio_enable_ff.sv
module cio_enable_ff (
    input  logic clk,
    input  logic rst,
    input  logic set_en,
    input  logic clr_en,
    output logic en_q
);
    always_ff @(posedge clk) begin
        if (rst)         en_q <= 1'b0;
        else if (clr_en) en_q <= 1'b0;
        else if (set_en) en_q <= 1'b1;
    end
endmodule

// File: rtl/char_io_port.sv
module char_io_port
    import cio_pkg::*;
#(
    parameter int ACC_W  = DEF_ACC_W,
    parameter int CHAR_W = DEF_CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_d7,
    input  logic              ir_ind,
    input  logic              t3,
    input  logic [N_CMD-1:0]  ir_sel,
    input  logic [ACC_W-1:0]  acc_in,
    output logic [ACC_W-1:0]  acc_out,
    output logic              acc_we,
    output logic              pc_skip,
    output logic              sc_clear,
    input  logic              kb_valid,
    input  logic [CHAR_W-1:0] kb_data,
    output logic              kb_ready,
    output logic              pr_valid,
    output logic [CHAR_W-1:0] pr_data,
    input  logic              pr_ack,
    output logic              irq
);
    localparam int HI_W = ACC_W - CHAR_W;

    logic              active;
    io_cmd_t           cmd;
    logic [CHAR_W-1:0] in_char;
    logic              in_flag;
    logic              out_flag;
    logic              int_en;

    cio_decode u_dec (
        .dec_d7 (dec_d7),
        .ir_ind (ir_ind),
        .t3     (t3),
        .ir_sel (ir_sel),
        .active (active),
        .cmd    (cmd)
    );

    cio_in_chan #(.W(CHAR_W)) u_in (
        .clk       (clk),
        .rst       (rst),
        .dev_valid (kb_valid),
        .dev_data  (kb_data),
        .cpu_take  (cmd.take_char),
        .dev_ready (kb_ready),
        .char_q    (in_char),
        .flag_q    (in_flag)
    );

    cio_out_chan #(.W(CHAR_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .cpu_load  (cmd.put_char),
        .cpu_data  (acc_in[CHAR_W-1:0]),
        .dev_ack   (pr_ack),
        .dev_valid (pr_valid),
        .char_q    (pr_data),
        .flag_q    (out_flag)
    );

    cio_enable_ff u_ien (
        .clk    (clk),
        .rst    (rst),
        .set_en (cmd.int_on),
        .clr_en (cmd.int_off),
        .en_q   (int_en)
    );

    if (HI_W > 0) begin : g_merge_hi
        assign acc_out = {acc_in[ACC_W-1:CHAR_W], in_char};
    end else begin : g_merge_eq
        assign acc_out = in_char[ACC_W-1:0];
    end

    assign sc_clear = active;
    assign acc_we   = cmd.take_char;
    assign pc_skip  = skip_request(cmd, in_flag, out_flag);
    assign irq      = irq_request(int_en, in_flag, out_flag);
endmodule

// File: rtl/cio_checker.sv
module cio_checker (
    input logic        clk,
    input logic        rst,
    input logic        sel_put,
    input logic        sel_on,
    input logic        sel_off,
    input logic [7:0]  acc_lo,
    input logic [7:0]  acc_in_hi,
    input logic [7:0]  acc_out_hi,
    input logic [7:0]  acc_out_lo,
    input logic        acc_we,
    input logic        pc_skip,
    input logic        sc_clear,
    input logic        kb_valid,
    input logic        kb_ready,
    input logic        pr_valid,
    input logic [7:0]  pr_data,
    input logic        pr_ack,
    input logic        irq
);
    // R1: reset state seen on the next cycle
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (kb_ready && !pr_valid && !irq && pr_data == 8'h00));

    // R2: no requests while inactive
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !sc_clear |-> (!pc_skip && !acc_we));

    // R3: upper accumulator byte passes through on an input instruction
    assert_hi_kept_R3: assert property (@(posedge clk) disable iff (rst)
        acc_we |-> (acc_out_hi == acc_in_hi));

    // R4 R12: output instruction leaves a pending character
    assert_out_load_R4: assert property (@(posedge clk) disable iff (rst)
        (sc_clear && sel_put) |=> (pr_valid && pr_data == $past(acc_lo)));

    // R8: accepted character makes the port busy
    assert_ready_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (kb_valid && kb_ready) |=> !kb_ready);

    // R8: received character changes only through an accepted load
    assert_char_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(kb_valid && kb_ready) |=> $stable(acc_out_lo));

    // R9: acknowledge consumes the pending character
    assert_ack_done_R9: assert property (@(posedge clk) disable iff (rst)
        (pr_valid && pr_ack && !(sc_clear && sel_put)) |=> !pr_valid);

    // R10: request only with a raised flag
    assert_irq_flag_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!kb_ready || !pr_valid));

    // R7: enabling exposes the flags on irq
    assert_int_on_R7: assert property (@(posedge clk) disable iff (rst)
        (sc_clear && sel_on && !sel_off) |=> (irq == (!kb_ready || !pr_valid)));

    // R7: disabling silences irq, also when both bits are set
    assert_int_off_R7: assert property (@(posedge clk) disable iff (rst)
        (sc_clear && sel_off) |=> !irq);
endmodule

bind char_io_port cio_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_put    (ir_sel[4]),
    .sel_on     (ir_sel[1]),
    .sel_off    (ir_sel[0]),
    .acc_lo     (acc_in[7:0]),
    .acc_in_hi  (acc_in[15:8]),
    .acc_out_hi (acc_out[15:8]),
    .acc_out_lo (acc_out[7:0]),
    .acc_we     (acc_we),
    .pc_skip    (pc_skip),
    .sc_clear   (sc_clear),
    .kb_valid   (kb_valid),
    .kb_ready   (kb_ready),
    .pr_valid   (pr_valid),
    .pr_data    (pr_data),
    .pr_ack     (pr_ack),
    .irq        (irq)
);

// File: tb/char_io_port_tb_top.sv
module char_io_port_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dec_d7 = 1'b0, ir_ind = 1'b0, t3 = 1'b0;
    logic [5:0]  ir_sel = '0;
    logic [15:0] acc_in = '0;
    logic [15:0] acc_out;
    logic        acc_we, pc_skip, sc_clear;
    logic        kb_valid = 1'b0;
    logic [7:0]  kb_data = '0;
    logic        kb_ready, pr_valid, pr_ack = 1'b0, irq;
    logic [7:0]  pr_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    char_io_port dut_i (
        .clk(clk), .rst(rst), .dec_d7(dec_d7), .ir_ind(ir_ind), .t3(t3),
        .ir_sel(ir_sel), .acc_in(acc_in), .acc_out(acc_out), .acc_we(acc_we),
        .pc_skip(pc_skip), .sc_clear(sc_clear), .kb_valid(kb_valid),
        .kb_data(kb_data), .kb_ready(kb_ready), .pr_valid(pr_valid),
        .pr_data(pr_data), .pr_ack(pr_ack), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] word;
        logic        t3v;
        logic [15:0] acc;
        logic        kbv;
        logic [7:0]  kbd;
        logic        ack;
        logic        e_skip;
        logic        e_we;
        logic        e_sc;
        logic [15:0] e_acc;
        logic        e_rdy;
        logic        e_pv;
        logic [7:0]  e_pd;
        logic        e_irq;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        // word   t3   acc      kbv  kbd    ack   skip we   sc   acc_out   rdy  pv   pd     irq
        '{16'h0000,1'b0,16'h0000,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b0,8'h00,1'b0}, // idle R1
        '{16'hF100,1'b1,16'h1234,1'b0,8'h00,1'b0, 1'b1,1'b0,1'b1,16'h1200, 1'b1,1'b0,8'h00,1'b0}, // R6 skip, flag 1
        '{16'hF200,1'b1,16'h0000,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b1,16'h0000, 1'b1,1'b0,8'h00,1'b0}, // R5 no skip
        '{16'h0000,1'b0,16'h0000,1'b1,8'h41,1'b0, 1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0,8'h00,1'b0}, // R8 load
        '{16'hF200,1'b1,16'hABCD,1'b0,8'h00,1'b0, 1'b1,1'b0,1'b1,16'hAB41, 1'b0,1'b0,8'h00,1'b0}, // R5 skip
        '{16'h0000,1'b0,16'h0000,1'b1,8'h55,1'b0, 1'b0,1'b0,1'b0,16'h0041, 1'b0,1'b0,8'h00,1'b0}, // R8 ignored
        '{16'hF800,1'b1,16'h5A00,1'b0,8'h00,1'b0, 1'b0,1'b1,1'b1,16'h5A41, 1'b1,1'b0,8'h00,1'b0}, // R3 input
        '{16'hF080,1'b1,16'h0000,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b1,16'h0041, 1'b1,1'b0,8'h00,1'b1}, // R7 R10 on
        '{16'hF400,1'b1,16'h77C3,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b1,16'h7741, 1'b1,1'b1,8'hC3,1'b0}, // R4 output
        '{16'hF100,1'b1,16'h0000,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b1,16'h0041, 1'b1,1'b1,8'hC3,1'b0}, // R6 no skip
        '{16'hF400,1'b0,16'h0099,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,16'h0041, 1'b1,1'b1,8'hC3,1'b0}, // R2 no t3
        '{16'h7400,1'b1,16'h0011,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,16'h0041, 1'b1,1'b1,8'hC3,1'b0}, // R2 I=0
        '{16'h0000,1'b0,16'h0000,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b0,16'h0041, 1'b1,1'b0,8'hC3,1'b1}, // R9 ack
        '{16'h0000,1'b0,16'h0000,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b0,16'h0041, 1'b1,1'b0,8'hC3,1'b1}, // R9 idle ack
        '{16'hF300,1'b1,16'h0000,1'b0,8'h00,1'b0, 1'b1,1'b0,1'b1,16'h0041, 1'b1,1'b0,8'hC3,1'b1}, // R13 both skips
        '{16'hF040,1'b1,16'h0000,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b1,16'h0041, 1'b1,1'b0,8'hC3,1'b0}, // R7 off
        '{16'hF080,1'b1,16'h0000,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b1,16'h0041, 1'b1,1'b0,8'hC3,1'b1}, // R7 on
        '{16'hF0C0,1'b1,16'h0000,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b1,16'h0041, 1'b1,1'b0,8'hC3,1'b0}, // R7 both: off wins
        '{16'hB800,1'b1,16'h0000,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,16'h0041, 1'b1,1'b0,8'hC3,1'b0}  // R2 opcode 011
    };

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input vec_t v);
        @(negedge clk);
        dec_d7   = (v.word[14:12] == 3'b111);
        ir_ind   = v.word[15];
        ir_sel   = v.word[11:6];
        t3       = v.t3v;
        acc_in   = v.acc;
        kb_valid = v.kbv;
        kb_data  = v.kbd;
        pr_ack   = v.ack;
        #1;
        chk("R5 R6 R13", "pc_skip", 16'(pc_skip), 16'(v.e_skip));
        chk("R3", "acc_we", 16'(acc_we), 16'(v.e_we));
        chk("R2", "sc_clear", 16'(sc_clear), 16'(v.e_sc));
        chk("R3 R11", "acc_out", acc_out, v.e_acc);
        @(posedge clk);
        #1;
        chk("R8 R11", "kb_ready", 16'(kb_ready), 16'(v.e_rdy));
        chk("R9 R12", "pr_valid", 16'(pr_valid), 16'(v.e_pv));
        chk("R4 R9", "pr_data", 16'(pr_data), 16'(v.e_pd));
        chk("R7 R10", "irq", 16'(irq), 16'(v.e_irq));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(5000 * 8);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: state while reset is held
        chk("R1", "kb_ready", 16'(kb_ready), 16'd1);
        chk("R1", "pr_valid", 16'(pr_valid), 16'd0);
        chk("R1", "irq", 16'(irq), 16'd0);
        chk("R1", "acc_out", acc_out, 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) step(TBL[i]);

        // R11: device load and input instruction in one cycle
        step('{16'hF800,1'b1,16'h1200,1'b1,8'h66,1'b0, 1'b0,1'b1,1'b1,16'h1241, 1'b0,1'b0,8'hC3,1'b0});
        step('{16'hF200,1'b1,16'h0000,1'b0,8'h00,1'b0, 1'b1,1'b0,1'b1,16'h0066, 1'b0,1'b0,8'hC3,1'b0});
        step('{16'hF800,1'b1,16'h0000,1'b0,8'h00,1'b0, 1'b0,1'b1,1'b1,16'h0066, 1'b1,1'b0,8'hC3,1'b0});

        // R12: output instruction and acknowledge in one cycle
        step('{16'hF400,1'b1,16'h0011,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b1,16'h0066, 1'b1,1'b1,8'h11,1'b0});
        step('{16'hF400,1'b1,16'h0022,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b1,16'h0066, 1'b1,1'b1,8'h22,1'b0});
        step('{16'h0000,1'b0,16'h0000,1'b0,8'h00,1'b1, 1'b0,1'b0,1'b0,16'h0066, 1'b1,1'b0,8'h22,1'b0});

        // enable plus a load, then reset mid-run (R1)
        step('{16'hF080,1'b1,16'h0000,1'b1,8'h77,1'b0, 1'b0,1'b0,1'b1,16'h0066, 1'b0,1'b0,8'h22,1'b1});
        @(negedge clk);
        rst = 1'b1;
        dec_d7 = 1'b0; ir_ind = 1'b0; t3 = 1'b0; ir_sel = '0;
        acc_in = '0; kb_valid = 1'b0; kb_data = '0; pr_ack = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", "kb_ready", 16'(kb_ready), 16'd1);
        chk("R1", "pr_valid", 16'(pr_valid), 16'd0);
        chk("R1", "pr_data", 16'(pr_data), 16'h0000);
        chk("R1", "irq", 16'(irq), 16'd0);
        chk("R1", "acc_out", acc_out, 16'h0000);
        @(negedge clk);
        rst = 1'b0;
        step('{16'hF100,1'b1,16'h0000,1'b0,8'h00,1'b0, 1'b1,1'b0,1'b1,16'h0000, 1'b1,1'b0,8'h00,1'b0});

        done = 1'b1;
        summary();
        $finish;
    end

endmodule